// File: doc/BRIEF.md
# Isochronous Complete-Split Descriptor Updater

This block sits in the periodic schedule path of a USB 2.0 host controller. For a split isochronous IN transfer descriptor it makes two decisions in one pass. First, it decides whether a complete-split may be issued in the current microframe. Second, once the result of the transaction is known, it computes the descriptor's new transfer state and says whether received data may go to memory.

The caller presents one request per cycle, qualified by `req_vld`. Each request carries the microframe number, the descriptor fields and the transaction outcome. One cycle later the block returns the registered result, qualified by `rsp_vld`. That result holds the go decision, the rewritten descriptor fields, a memory-write strobe and the number of bytes to write.

Bus signalling, CRC computation, memory traversal and fetching through the back pointer all happen outside this block. Back-pointer use reaches the block only as the `bp_used` flag.

Top module: `iso_csplit_updater`

## Requirements
- R1: The microframe number `uf_idx` selects the current bit `1 << uf_idx` of the 8-bit masks. The previous bit is the current bit rotated right by one, so bit 0 wraps to bit 7.
- R2: The previous-completion check fails only when the previous bit is set in `cs_mask` and clear in `prog_mask`. In every other case it passes.
- R3: When `uf_idx` is 0 or 1 and `bp_used` is 0, the previous-completion check is not applied and counts as passed. For any other value of `uf_idx`, or when `bp_used` is 1, the check is applied.
- R4: `go` is 1 only when `act_in` is 1, the current bit is set in `cs_mask` and the previous-completion check passes.
- R5: When `go` is 1, `prog_out` equals `prog_mask` ORed with the current bit. Otherwise `prog_out` equals `prog_mask`.
- R6: On an accepted packet, `bytes_out` is `bytes_left - rx_len` and `off_out` is `(cur_off + rx_len) mod 4096`. `wr_en` is 1 and `wr_len` equals `rx_len`. A packet is accepted when `go` is 1, `rx_data` is 1, `rx_crc_ok` is 1, `rx_len <= 192` and `rx_len <= bytes_left`.
- R7: On an accepted packet, `page_out` becomes 1 when `cur_off + rx_len` carries out of the 12-bit offset. If there is no carry, `page_out` equals `page_sel`.
- R8: Babble: the packet arrives with `go`, `rx_data` and `rx_crc_ok` all 1, but `rx_len > bytes_left` (this includes data arriving with 0 bytes left) or `rx_len > 192`. In that case `wr_en` is 0, `act_out` is 0, status bit 4 is set in `stat_out`, and the byte count, offset and page fields are unchanged.
- R9: When `go` is 0 (including an inactive descriptor), or when `go` is 1 but either `rx_data` or `rx_crc_ok` is 0, all transfer fields, `act_out` and `stat_out` are unchanged and `wr_en` is 0.
- R10: `rsp_vld` follows `req_vld` by one cycle. After reset, `rsp_vld`, `go` and `wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request present this cycle |
| uf_idx | input | 3 | Low three bits of the microframe index |
| bp_used | input | 1 | Descriptor was reached through the back pointer |
| cs_mask | input | 8 | Complete-split intent mask |
| prog_mask | input | 8 | Complete-split progress mask |
| bytes_left | input | BYTES_W | Total bytes still to transfer |
| cur_off | input | OFF_W | Current offset within the page |
| page_sel | input | 1 | Page-select bit |
| act_in | input | 1 | Descriptor active flag |
| stat_in | input | 8 | Descriptor status bits |
| rx_data | input | 1 | A data packet was received |
| rx_crc_ok | input | 1 | Received packet CRC was good |
| rx_len | input | LEN_W | Received payload length in bytes |
| rsp_vld | output | 1 | Response valid |
| go | output | 1 | Complete-split was committed |
| prog_out | output | 8 | Updated progress mask |
| bytes_out | output | BYTES_W | Updated bytes remaining |
| off_out | output | OFF_W | Updated offset |
| page_out | output | 1 | Updated page-select bit |
| act_out | output | 1 | Updated active flag |
| stat_out | output | 8 | Updated status bits |
| wr_en | output | 1 | Received data may be written to memory |
| wr_len | output | LEN_W | Number of bytes to write |

## Verification
A wrong rotation or a misplaced boundary test in the gate shows up in the same response as a wrong `go` and an unchanged `prog_out`. The cases that expose this are microframe 0 with the top mask bit set, and microframes 0 and 1 with and without `bp_used`. A fault in the arithmetic shows up at once as a wrong remaining count, wrong offset or wrong page bit; offsets near 4096 expose carry and wrap errors. A wrong babble bound shows up in the response to a 192- or 193-byte packet, or to data arriving with nothing left: `wr_en` is set, `act_out` stays high or status bit 4 stays clear. Every field is registered exactly once, so any such error appears in the response to the request that caused it, one cycle after that request.

// File: rtl/iso_csplit_pkg.sv
package iso_csplit_pkg;
    localparam int MASK_W      = 8;
    localparam int MAX_PAYLOAD = 192;
    localparam int BABBLE_BIT  = 4;

    function automatic logic [MASK_W-1:0] rot_right1(input logic [MASK_W-1:0] v);
        return {v[0], v[MASK_W-1:1]};
    endfunction
endpackage

// File: rtl/csplit_gate.sv
module csplit_gate
    import iso_csplit_pkg::*;
(
    input  logic [2:0]        uf_idx,
    input  logic              bp_used,
    input  logic [MASK_W-1:0] cs_mask,
    input  logic [MASK_W-1:0] prog_mask,
    input  logic              act_in,
    output logic [MASK_W-1:0] cur_bit,
    output logic              go
);
    logic [MASK_W-1:0] prev_bit;
    logic              boundary;
    logic              apply_chk;
    logic              prev_ok;

    always_comb begin
        cur_bit   = MASK_W'(1) << uf_idx;
        prev_bit  = rot_right1(cur_bit);
        boundary  = (uf_idx == 3'd0) || (uf_idx == 3'd1);
        apply_chk = !boundary || bp_used;
        prev_ok   = !(apply_chk && |(prev_bit & cs_mask) && !(|(prev_bit & prog_mask)));
        go        = act_in && |(cur_bit & cs_mask) && prev_ok;
    end
endmodule

// File: rtl/sitd_advance.sv
module sitd_advance
    import iso_csplit_pkg::*;
#(
    parameter int BYTES_W = 10,
    parameter int OFF_W   = 12,
    parameter int LEN_W   = 9
) (
    input  logic               go,
    input  logic [BYTES_W-1:0] bytes_left,
    input  logic [OFF_W-1:0]   cur_off,
    input  logic               page_sel,
    input  logic               act_in,
    input  logic [7:0]         stat_in,
    input  logic               rx_data,
    input  logic               rx_crc_ok,
    input  logic [LEN_W-1:0]   rx_len,
    output logic [BYTES_W-1:0] bytes_nx,
    output logic [OFF_W-1:0]   off_nx,
    output logic               page_nx,
    output logic               act_nx,
    output logic [7:0]         stat_nx,
    output logic               wr_nx,
    output logic [LEN_W-1:0]   wr_len_nx
);
    localparam int SUM_W = OFF_W + 1;
    localparam int CMP_W = (BYTES_W > LEN_W) ? BYTES_W : LEN_W;

    logic [SUM_W-1:0] off_sum;
    logic             too_big;
    logic             no_room;
    logic             good_pkt;

    always_comb begin
        off_sum   = {1'b0, cur_off} + SUM_W'(rx_len);
        too_big   = rx_len > LEN_W'(MAX_PAYLOAD);
        no_room   = CMP_W'(rx_len) > CMP_W'(bytes_left);
        good_pkt  = go && rx_data && rx_crc_ok;

        bytes_nx  = bytes_left;
        off_nx    = cur_off;
        page_nx   = page_sel;
        act_nx    = act_in;
        stat_nx   = stat_in;
        wr_nx     = 1'b0;
        wr_len_nx = '0;

        if (good_pkt) begin
            if (too_big || no_room) begin
                act_nx             = 1'b0;
                stat_nx[BABBLE_BIT] = 1'b1;
            end else begin
                bytes_nx  = bytes_left - BYTES_W'(rx_len);
                off_nx    = off_sum[OFF_W-1:0];
                page_nx   = page_sel | off_sum[OFF_W];
                wr_nx     = 1'b1;
                wr_len_nx = rx_len;
            end
        end
    end
endmodule

// File: rtl/iso_csplit_updater.sv
module iso_csplit_updater
    import iso_csplit_pkg::*;
#(
    parameter int BYTES_W = 10,
    parameter int OFF_W   = 12,
    parameter int LEN_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_vld,
    input  logic [2:0]         uf_idx,
    input  logic               bp_used,
    input  logic [7:0]         cs_mask,
    input  logic [7:0]         prog_mask,
    input  logic [BYTES_W-1:0] bytes_left,
    input  logic [OFF_W-1:0]   cur_off,
    input  logic               page_sel,
    input  logic               act_in,
    input  logic [7:0]         stat_in,
    input  logic               rx_data,
    input  logic               rx_crc_ok,
    input  logic [LEN_W-1:0]   rx_len,
    output logic               rsp_vld,
    output logic               go,
    output logic [7:0]         prog_out,
    output logic [BYTES_W-1:0] bytes_out,
    output logic [OFF_W-1:0]   off_out,
    output logic               page_out,
    output logic               act_out,
    output logic [7:0]         stat_out,
    output logic               wr_en,
    output logic [LEN_W-1:0]   wr_len
);
    typedef struct packed {
        logic               vld;
        logic               go;
        logic [7:0]         prog;
        logic [BYTES_W-1:0] bytes;
        logic [OFF_W-1:0]   off;
        logic               page;
        logic               act;
        logic [7:0]         stat;
        logic               wr;
        logic [LEN_W-1:0]   wlen;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [7:0]         cur_bit;
    logic               go_c;
    logic [BYTES_W-1:0] bytes_nx;
    logic [OFF_W-1:0]   off_nx;
    logic               page_nx;
    logic               act_nx;
    logic [7:0]         stat_nx;
    logic               wr_nx;
    logic [LEN_W-1:0]   wr_len_nx;

    csplit_gate u_gate (
        .uf_idx    (uf_idx),
        .bp_used   (bp_used),
        .cs_mask   (cs_mask),
        .prog_mask (prog_mask),
        .act_in    (act_in),
        .cur_bit   (cur_bit),
        .go        (go_c)
    );

    sitd_advance #(
        .BYTES_W (BYTES_W),
        .OFF_W   (OFF_W),
        .LEN_W   (LEN_W)
    ) u_adv (
        .go         (go_c),
        .bytes_left (bytes_left),
        .cur_off    (cur_off),
        .page_sel   (page_sel),
        .act_in     (act_in),
        .stat_in    (stat_in),
        .rx_data    (rx_data),
        .rx_crc_ok  (rx_crc_ok),
        .rx_len     (rx_len),
        .bytes_nx   (bytes_nx),
        .off_nx     (off_nx),
        .page_nx    (page_nx),
        .act_nx     (act_nx),
        .stat_nx    (stat_nx),
        .wr_nx      (wr_nx),
        .wr_len_nx  (wr_len_nx)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.vld   = req_vld;
        if (req_vld) begin
            rsp_d.go    = go_c;
            rsp_d.prog  = go_c ? (prog_mask | cur_bit) : prog_mask;
            rsp_d.bytes = bytes_nx;
            rsp_d.off   = off_nx;
            rsp_d.page  = page_nx;
            rsp_d.act   = act_nx;
            rsp_d.stat  = stat_nx;
            rsp_d.wr    = wr_nx;
            rsp_d.wlen  = wr_len_nx;
        end else begin
            rsp_d.go = 1'b0;
            rsp_d.wr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_vld   = rsp_q.vld;
    assign go        = rsp_q.go;
    assign prog_out  = rsp_q.prog;
    assign bytes_out = rsp_q.bytes;
    assign off_out   = rsp_q.off;
    assign page_out  = rsp_q.page;
    assign act_out   = rsp_q.act;
    assign stat_out  = rsp_q.stat;
    assign wr_en     = rsp_q.wr;
    assign wr_len    = rsp_q.wlen;
endmodule

// File: rtl/iso_csplit_checker.sv
module iso_csplit_checker #(
    parameter int BYTES_W = 10,
    parameter int OFF_W   = 12,
    parameter int LEN_W   = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_vld,
    input logic [2:0]         uf_idx,
    input logic [7:0]         cs_mask,
    input logic [7:0]         prog_mask,
    input logic               act_in,
    input logic               rsp_vld,
    input logic               go,
    input logic [7:0]         prog_out,
    input logic               act_out,
    input logic [7:0]         stat_out,
    input logic               wr_en,
    input logic [LEN_W-1:0]   wr_len
);
    assert_vld_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    assert_go_needs_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !act_in) |=> !go);

    assert_go_needs_intent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !cs_mask[uf_idx]) |=> !go);

    assert_prog_marks_cur_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && go) |-> prog_out[$past(uf_idx)]);

    assert_prog_keeps_old_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> ((prog_out & $past(prog_mask)) == $past(prog_mask)));

    assert_write_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (go && rsp_vld && wr_len <= LEN_W'(192)));

    assert_babble_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && go && !act_out) |-> (stat_out[4] && !wr_en));

    assert_no_write_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |-> (!wr_en && !go));
endmodule

bind iso_csplit_updater iso_csplit_checker #(
    .BYTES_W (BYTES_W),
    .OFF_W   (OFF_W),
    .LEN_W   (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .uf_idx    (uf_idx),
    .cs_mask   (cs_mask),
    .prog_mask (prog_mask),
    .act_in    (act_in),
    .rsp_vld   (rsp_vld),
    .go        (go),
    .prog_out  (prog_out),
    .act_out   (act_out),
    .stat_out  (stat_out),
    .wr_en     (wr_en),
    .wr_len    (wr_len)
);

// File: tb/sim_iso_csplit_updater.sv
`timescale 1ns/1ps
module sim_iso_csplit_updater;
    localparam int BW = 10;
    localparam int OW = 12;
    localparam int LW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_vld = 1'b0;
    logic [2:0]    uf_idx = '0;
    logic          bp_used = 1'b0;
    logic [7:0]    cs_mask = '0;
    logic [7:0]    prog_mask = '0;
    logic [BW-1:0] bytes_left = '0;
    logic [OW-1:0] cur_off = '0;
    logic          page_sel = 1'b0;
    logic          act_in = 1'b0;
    logic [7:0]    stat_in = '0;
    logic          rx_data = 1'b0;
    logic          rx_crc_ok = 1'b0;
    logic [LW-1:0] rx_len = '0;

    logic          rsp_vld, go, page_out, act_out, wr_en;
    logic [7:0]    prog_out, stat_out;
    logic [BW-1:0] bytes_out;
    logic [OW-1:0] off_out;
    logic [LW-1:0] wr_len;

    always #2.5 clk = ~clk;

    iso_csplit_updater #(.BYTES_W(BW), .OFF_W(OW), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .uf_idx(uf_idx),
        .bp_used(bp_used), .cs_mask(cs_mask), .prog_mask(prog_mask),
        .bytes_left(bytes_left), .cur_off(cur_off), .page_sel(page_sel),
        .act_in(act_in), .stat_in(stat_in), .rx_data(rx_data),
        .rx_crc_ok(rx_crc_ok), .rx_len(rx_len), .rsp_vld(rsp_vld), .go(go),
        .prog_out(prog_out), .bytes_out(bytes_out), .off_out(off_out),
        .page_out(page_out), .act_out(act_out), .stat_out(stat_out),
        .wr_en(wr_en), .wr_len(wr_len)
    );

    typedef struct {
        string         tag;
        logic          go;
        logic [7:0]    prog;
        logic [BW-1:0] bytes;
        logic [OW-1:0] off;
        logic          page;
        logic          act;
        logic [7:0]    stat;
        logic          wr;
        logic [LW-1:0] wlen;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Expectation written from the requirement text.
    task automatic drive(input string tag, input int idx, input bit bp, input int cm, input int pm,
                         input int tot, input int off, input bit pg, input bit act,
                         input int st, input bit dat, input bit crc, input int len);
        exp_t e;
        int   prev_idx;
        bit   intent_prev, done_prev, skip, pass, g;
        int   sum;
        prev_idx    = (idx + 7) % 8;
        intent_prev = cm[prev_idx];
        done_prev   = pm[prev_idx];
        skip        = (idx <= 1) && !bp;
        pass        = skip || !intent_prev || done_prev;
        g           = act && cm[idx] && pass;
        e.tag  = tag;
        e.go   = g;
        e.prog = g ? 8'(pm | (1 << idx)) : 8'(pm);
        e.bytes = BW'(tot); e.off = OW'(off); e.page = pg; e.act = act;
        e.stat = 8'(st); e.wr = 1'b0; e.wlen = '0;
        if (g && dat && crc) begin
            if (len > 192 || len > tot) begin
                e.act = 1'b0;
                e.stat = 8'(st | 16);
            end else begin
                sum     = off + len;
                e.bytes = BW'(tot - len);
                e.off   = OW'(sum % 4096);
                e.page  = pg | (sum >= 4096);
                e.wr    = 1'b1;
                e.wlen  = LW'(len);
            end
        end
        @(negedge clk);
        req_vld = 1'b1; uf_idx = 3'(idx); bp_used = bp; cs_mask = 8'(cm);
        prog_mask = 8'(pm); bytes_left = BW'(tot); cur_off = OW'(off);
        page_sel = pg; act_in = act; stat_in = 8'(st); rx_data = dat;
        rx_crc_ok = crc; rx_len = LW'(len);
        exp_q.push_back(e);
    endtask

    // Monitor: compares each response one cycle after its request.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (rsp_vld === 1'b1) begin
                if (exp_q.size() == 0) begin
                    check("R10", "unexpected response", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(e.tag, "go",     int'(go),        int'(e.go));
                    check(e.tag, "prog",   int'(prog_out),  int'(e.prog));
                    check(e.tag, "bytes",  int'(bytes_out), int'(e.bytes));
                    check(e.tag, "off",    int'(off_out),   int'(e.off));
                    check(e.tag, "page",   int'(page_out),  int'(e.page));
                    check(e.tag, "act",    int'(act_out),   int'(e.act));
                    check(e.tag, "stat",   int'(stat_out),  int'(e.stat));
                    check(e.tag, "wr_en",  int'(wr_en),     int'(e.wr));
                    check(e.tag, "wr_len", int'(wr_len),    int'(e.wlen));
                end
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            check("watchdog", "timeout", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R10", "reset rsp_vld", int'(rsp_vld), 0);
        check("R10", "reset go", int'(go), 0);
        check("R10", "reset wr_en", int'(wr_en), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // tag, idx, bp, cmask, pmask, total, off, page, active, stat, data, crc, len
        drive("R6_normal",        3, 0, 'h18, 'h00, 100,   10, 0, 1, 0, 1, 1, 40);
        drive("R2_prev_missing",  4, 0, 'h18, 'h00, 100,   10, 0, 1, 0, 1, 1, 40);
        drive("R2_prev_done",     4, 0, 'h18, 'h08, 100,   10, 0, 1, 0, 1, 1, 40);
        drive("R1_wrap_fail",     0, 1, 'h81, 'h00,  50,    0, 0, 1, 0, 1, 1, 8);
        drive("R3_deferred",      0, 0, 'h81, 'h00,  50,    0, 0, 1, 0, 1, 1, 8);
        drive("R3_idx1_deferred", 1, 0, 'h03, 'h00,  50,    0, 0, 1, 0, 1, 1, 8);
        drive("R1_wrap_pass",     0, 1, 'h81, 'h80,  50,    0, 0, 1, 0, 1, 1, 8);
        drive("R4_no_intent",     5, 0, 'h08, 'h00,  50,    0, 0, 1, 0, 1, 1, 8);
        drive("R9_inactive",      3, 0, 'h08, 'h00,  50,    0, 0, 0, 2, 1, 1, 8);
        drive("R8_zero_left",     6, 0, 'h40, 'h00,   0,  300, 0, 1, 1, 1, 1, 5);
        drive("R8_over_192",      2, 0, 'h04, 'h00, 300,  300, 0, 1, 0, 1, 1, 193);
        drive("R6_exact_192",     2, 0, 'h04, 'h00, 300,  300, 0, 1, 0, 1, 1, 192);
        drive("R8_over_left",     2, 0, 'h04, 'h00,  20,  300, 0, 1, 0, 1, 1, 21);
        drive("R7_page_cross",    7, 0, 'hC0, 'h40, 400, 4000, 0, 1, 0, 1, 1, 150);
        drive("R7_to_edge",       7, 0, 'hC0, 'h40, 400, 3946, 0, 1, 0, 1, 1, 150);
        drive("R9_bad_crc",       3, 0, 'h08, 'h00, 100,   10, 0, 1, 0, 1, 0, 40);
        drive("R5_no_data",       3, 0, 'h08, 'h00, 100,   10, 0, 1, 0, 0, 1, 0);
        @(negedge clk);
        req_vld = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        check("R10", "idle rsp_vld", int'(rsp_vld), 0);
        check("R10", "queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule